// File: doc/BRIEF.md
# HDLC Receive Frame Checker

This block sits behind an HDLC receiver's zero-bit destuffer and flag detector. It takes a stream of data bits together with two event strobes: one for a flag, and one for a run of seven or more ones. From these it rebuilds each frame between its flags. It packs the data bits into octets, least significant bit first, and passes them out on a byte stream. The received CRC octets are passed out as well.

When a frame closes, the block emits a one-cycle completion pulse. With the pulse it presents the octet length and a set of status bits: abort, non-octet length, length violation, CRC error, and short frame for signalling-mode links. The CRC is CRC-16/CCITT, processed least significant bit first with an all-ones preset. A correct frame, including its transmitted complemented FCS, leaves the register at 0xF0B8.

A single flag may close one frame and open the next. Repeated flags with no data between them are idle fill. A seven-ones run inside a frame ends that frame with the abort bit set. The block then waits for the next flag. Once the programmed maximum length is exceeded, further octets are discarded, but counting continues until the closing flag.

Top module: `hdlc_rx_checker`

## Requirements
- R1: After reset `byte_vld` and `done` are low and `st_len` is 0. No frame is open, so bits that arrive before the first flag produce no byte and no status.
- R2: Data bits are packed least significant bit first. `byte_vld` pulses in the cycle after the clock edge that takes the eighth bit of an octet, and `byte_out` then holds that octet.
- R3: A flag that follows at least one data bit since the last flag closes the frame. `done` pulses in the next cycle, and `st_len` holds the number of complete octets received. The same flag opens the next frame. A flag with no bits since the previous flag produces no `done`.
- R4: `st_nonoct` is set when the frame's bit count is not a multiple of 8. This includes the one-bit frame, which reports length 0.
- R5: A seven-ones event in an open frame that has at least one bit closes the frame with `st_abort` set. Bits and seven-ones events after that are ignored until the next flag.
- R6: A seven-ones event with no bits since the last flag, or outside a frame, produces no `done` and no byte.
- R7: Only the first `max_len` octets of a frame are forwarded on `byte_vld`. `st_len` still counts every octet up to the closing flag. `st_toolong` is set exactly when `st_len` > `max_len`.
- R8: `st_crcerr` is clear exactly when the CRC register ends at 0xF0B8 over all received bits. The register uses reflected polynomial 0x8408 and an all-ones preset. The two FCS octets are forwarded like data.
- R9: `st_short` is set when `ss7_mode` is high and `st_len` < 5; otherwise it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss7_mode | input | 1 | Enables the short-frame check |
| max_len | input | LEN_W | Largest number of octets forwarded per frame |
| bit_vld | input | 1 | A destuffed data bit is present |
| bit_in | input | 1 | Data bit value |
| flag_det | input | 1 | Flag received (takes priority) |
| ones7 | input | 1 | Run of seven or more ones received |
| byte_vld | output | 1 | Octet strobe |
| byte_out | output | 8 | Received octet |
| done | output | 1 | Frame-complete pulse |
| st_len | output | LEN_W | Octet count of the closed frame |
| st_nonoct | output | 1 | Bit count not a multiple of 8 |
| st_abort | output | 1 | Frame ended by a seven-ones run |
| st_toolong | output | 1 | Length exceeded `max_len` |
| st_crcerr | output | 1 | CRC residue mismatch |
| st_short | output | 1 | Signalling-mode frame under 5 octets |

## Verification
The frame state is flushed at every flag, so a fault in the bit phase, octet count or CRC register shows up at the latest on the next `done` of the same frame. It appears as a wrong length, a wrong status bit, or a byte appearing one cycle off. A wrong open/closed frame state shows up as a `done` that is missing or spurious after a seven-ones event or a repeated flag. The sweeps cover every length around the 5-octet and maximum-length boundaries, every residual bit count, and both CRC outcomes, so such faults reach the ports within one frame.

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker #(
  parameter int LEN_W = 12,
  parameter int MIN_SS7 = 5,
  parameter logic [15:0] RESIDUE = 16'hF0B8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ss7_mode,
  input  logic [LEN_W-1:0] max_len,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             flag_det,
  input  logic             ones7,
  output logic             byte_vld,
  output logic [7:0]       byte_out,
  output logic             done,
  output logic [LEN_W-1:0] st_len,
  output logic             st_nonoct,
  output logic             st_abort,
  output logic             st_toolong,
  output logic             st_crcerr,
  output logic             st_short
);
  logic             in_frame;
  logic [7:0]       sr;
  logic [2:0]       ph;
  logic [LEN_W-1:0] oct;
  logic [15:0]      crc;

  wire        any_bits = (oct != '0) || (ph != 3'd0);
  wire        closing  = in_frame && any_bits && (flag_det || ones7);
  wire [7:0]  sr_nx    = {bit_in, sr[7:1]};
  wire [15:0] crc_nx   = {1'b0, crc[15:1]} ^ ((crc[0] ^ bit_in) ? 16'h8408 : 16'h0000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      sr         <= '0;
      ph         <= '0;
      oct        <= '0;
      crc        <= 16'hFFFF;
      byte_vld   <= 1'b0;
      byte_out   <= '0;
      done       <= 1'b0;
      st_len     <= '0;
      st_nonoct  <= 1'b0;
      st_abort   <= 1'b0;
      st_toolong <= 1'b0;
      st_crcerr  <= 1'b0;
      st_short   <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      done     <= closing;
      if (closing) begin
        st_len     <= oct;
        st_nonoct  <= ph != 3'd0;
        st_abort   <= !flag_det;
        st_toolong <= oct > max_len;
        st_crcerr  <= crc != RESIDUE;
        st_short   <= ss7_mode && (oct < LEN_W'(MIN_SS7));
      end
      if (flag_det || ones7) begin
        in_frame <= flag_det;
        ph       <= '0;
        oct      <= '0;
        crc      <= 16'hFFFF;
      end else if (bit_vld && in_frame) begin
        sr  <= sr_nx;
        crc <= crc_nx;
        ph  <= ph + 3'd1;
        if (ph == 3'd7) begin
          if (!(&oct)) oct <= oct + 1'b1;
          if (oct < max_len) begin
            byte_vld <= 1'b1;
            byte_out <= sr_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_checker_sva.sv
module hdlc_rx_checker_sva #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss7_mode,
  input logic [LEN_W-1:0] max_len,
  input logic             bit_vld,
  input logic             flag_det,
  input logic             ones7,
  input logic             byte_vld,
  input logic             done,
  input logic             st_abort,
  input logic             st_short
);
  logic [LEN_W-1:0] fwd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) fwd_cnt <= '0;
    else if (flag_det || ones7) fwd_cnt <= '0;
    else if (byte_vld) fwd_cnt <= fwd_cnt + 1'b1;
  end

  p_byte_after_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(bit_vld));

  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(flag_det) || $past(ones7)));

  p_abort_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_abort) |-> $past(ones7));

  p_fwd_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (fwd_cnt < max_len));

  p_short_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_short) |-> $past(ss7_mode));
endmodule

bind hdlc_rx_checker hdlc_rx_checker_sva #(.LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ss7_mode(ss7_mode), .max_len(max_len),
  .bit_vld(bit_vld), .flag_det(flag_det), .ones7(ones7),
  .byte_vld(byte_vld), .done(done), .st_abort(st_abort), .st_short(st_short)
);

// File: tb/hdlc_rx_checker_test.sv
`timescale 1ns/1ps
module hdlc_rx_checker_test;
  localparam int LW = 12;
  localparam int MAXL = 12;

  logic clk = 1'b0, rst_n = 1'b0, ss7_mode = 1'b0;
  logic [LW-1:0] max_len = LW'(MAXL);
  logic bit_vld = 1'b0, bit_in = 1'b0, flag_det = 1'b0, ones7 = 1'b0;
  logic byte_vld, done, st_nonoct, st_abort, st_toolong, st_crcerr, st_short;
  logic [7:0] byte_out;
  logic [LW-1:0] st_len;

  int checks = 0, errors = 0;
  int ncap = 0, ndone = 0;
  logic [7:0] cap [64];

  always #5 clk = ~clk;

  hdlc_rx_checker #(.LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .ss7_mode(ss7_mode), .max_len(max_len),
    .bit_vld(bit_vld), .bit_in(bit_in), .flag_det(flag_det), .ones7(ones7),
    .byte_vld(byte_vld), .byte_out(byte_out), .done(done), .st_len(st_len),
    .st_nonoct(st_nonoct), .st_abort(st_abort), .st_toolong(st_toolong),
    .st_crcerr(st_crcerr), .st_short(st_short)
  );

  always @(negedge clk) begin
    if (byte_vld) begin
      if (ncap < 64) cap[ncap] = byte_out;
      ncap++;
    end
    if (done) ndone++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
    return {1'b0, c[15:1]} ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic send_bit(input logic b);
    bit_vld = 1'b1; bit_in = b; tick(); bit_vld = 1'b0;
  endtask
  task automatic send_flag(); flag_det = 1'b1; tick(); flag_det = 1'b0; endtask
  task automatic send_ones7(); ones7 = 1'b1; tick(); ones7 = 1'b0; endtask

  // fcs: 0 none, 1 good, 2 corrupted
  task automatic frame(input int nb, input int fcs, input int extra, input bit abrt);
    logic [7:0] fr [32];
    logic [15:0] c;
    int t, fwd;
    c = 16'hFFFF;
    for (int i = 0; i < nb; i++) begin
      fr[i] = 8'((i * 37 + nb * 11 + 5) & 255);
      for (int k = 0; k < 8; k++) c = crc_upd(c, fr[i][k]);
    end
    t = nb;
    if (fcs != 0) begin
      c = ~c;
      if (fcs == 2) c = c ^ 16'h0001;
      fr[nb] = c[7:0]; fr[nb+1] = c[15:8];
      t = nb + 2;
    end
    ncap = 0; ndone = 0;
    c = 16'hFFFF;
    for (int i = 0; i < t; i++)
      for (int k = 0; k < 8; k++) begin
        send_bit(fr[i][k]);
        c = crc_upd(c, fr[i][k]);
        if (i == 0 && k == 7) chk(byte_vld === 1'b1, "R2 byte strobe after 8th bit", int'(byte_vld), 1);
      end
    for (int k = 0; k < extra; k++) begin
      send_bit(k[0]);
      c = crc_upd(c, k[0]);
    end
    if (abrt) send_ones7(); else send_flag();
    tick();
    fwd = (t < MAXL) ? t : MAXL;
    chk(ndone == 1, "R3 one done per frame", ndone, 1);
    chk(int'(st_len) == t, "R3 length", int'(st_len), t);
    chk(st_nonoct == ((extra % 8) != 0), "R4 nonoctet", int'(st_nonoct), int'((extra % 8) != 0));
    chk(st_abort == abrt, "R5 abort bit", int'(st_abort), int'(abrt));
    chk(st_toolong == (t > MAXL), "R7 toolong", int'(st_toolong), int'(t > MAXL));
    chk(ncap == fwd, "R7 forwarded count", ncap, fwd);
    for (int i = 0; i < fwd && i < ncap; i++)
      chk(cap[i] == fr[i], "R2 R8 octet value", int'(cap[i]), int'(fr[i]));
    chk(st_crcerr == (c != 16'hF0B8), "R8 crc error", int'(st_crcerr), int'(c != 16'hF0B8));
    chk(st_short == (ss7_mode && t < 5), "R9 short frame", int'(st_short), int'(ss7_mode && t < 5));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(byte_vld == 0 && done == 0, "R1 reset outputs", int'(byte_vld) + int'(done), 0);
    chk(st_len == 0, "R1 reset length", int'(st_len), 0);
    ncap = 0; ndone = 0;
    for (int i = 0; i < 16; i++) send_bit(1'(i % 3 == 0));
    tick();
    chk(ncap == 0 && ndone == 0, "R1 bits before first flag ignored", ncap + ndone, 0);

    send_flag(); send_flag(); send_flag(); tick();
    chk(ndone == 0, "R3 repeated flags no done", ndone, 0);

    for (int m = 0; m < 2; m++) begin
      ss7_mode = 1'(m);
      for (int nb = 0; nb <= 13; nb++) frame(nb, 1, 0, 1'b0);
    end
    ss7_mode = 1'b1;
    for (int e = 1; e <= 7; e++) frame(3, 1, e, 1'b0);
    frame(0, 0, 1, 1'b0);
    frame(4, 2, 0, 1'b0);
    frame(9, 2, 0, 1'b0);
    ss7_mode = 1'b0;
    frame(3, 0, 5, 1'b1);

    ncap = 0; ndone = 0;
    for (int i = 0; i < 24; i++) send_bit(1'(i % 2));
    send_ones7(); tick();
    chk(ncap == 0, "R5 bits after abort ignored", ncap, 0);
    chk(ndone == 0, "R6 ones7 outside frame", ndone, 0);
    send_flag(); send_ones7(); tick();
    chk(ndone == 0, "R6 ones7 right after flag", ndone, 0);
    send_flag();
    frame(6, 1, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule